// File: doc/BRIEF.md
# Self-Test Result History Sector

This block keeps a rolling record of the outcomes of device self-tests and shows that record as one fixed 512-byte sector. Each finished test hands the block one result record: a test number, an execution status, a 16-bit power-on hour stamp, a failure checkpoint code and the 32-bit address of the first failing block. The block keeps the most recent results, up to a fixed depth. When the store is full, each new result replaces the oldest one.

A host-side reader fetches the sector one byte at a time by giving a byte index. One cycle later the block returns the serialized byte. The serialized image has a revision word at the start, one fixed-size descriptor per stored result, a pointer to the newest descriptor near the end, and a final checksum byte that makes the whole sector sum to zero. A synchronous clear empties the history.

Top module: `selog_top`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, the log is empty. The pointer byte (index 508) reads 0, and every descriptor byte (indices 2..505) reads 0x00.
- R2: Byte index 0 reads 0x01 and byte index 1 reads 0x00 (revision word 0x0001, low byte first).
- R3: Descriptor k (0-based, k = 0..20) occupies indices 24*k+2 to 24*k+25. Its byte +0 holds the test number, +1 the execution status, +2..+3 the power-on hours, +4 the failure checkpoint and +5..+8 the first-failure address.
- R4: The hours field and the address field are serialized least-significant byte first.
- R5: Each accepted write advances the pointer byte by one, through the values 1..21. The newest result sits in descriptor (pointer − 1). The pointer does not change when there is no write.
- R6: A write that arrives when the pointer is 21 stores into descriptor 0, replacing the oldest result, and sets the pointer to 1. The other descriptors keep their contents.
- R7: Byte index 511 is a checksum chosen so that the sum of all 512 bytes, taken modulo 256, is 0.
- R8: Descriptor bytes +9..+23, the unused descriptor slots and all other bytes (indices 506, 507, 509, 510) read 0x00.
- R9: `rd_data` is valid with `rd_valid` high exactly one cycle after `rd_en`. `rd_valid` is low in every other cycle.
- R10: A read issued in the same cycle as a write returns the contents from before that write.
- R11: When `clr` and `wr_en` are high in the same cycle, the clear wins and the record is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the whole history |
| wr_en | input | 1 | Accept one result record this cycle |
| wr_test_num | input | 8 | Test number of the result |
| wr_status | input | 8 | Execution status of the result |
| wr_hours | input | 16 | Power-on hours at test time |
| wr_chkpt | input | 8 | Failure checkpoint code |
| wr_lba | input | 32 | Address of the first failure |
| rd_en | input | 1 | Read request |
| rd_idx | input | 9 | Byte index 0..511 into the sector |
| rd_data | output | 8 | Sector byte returned one cycle after `rd_en` |
| rd_valid | output | 1 | `rd_data` is valid |

## Verification
A wrong write slot or a wrong wrap decision shows at the ports the next time the affected descriptor is read. The pointer byte at index 508 exposes any slip in the pointer one cycle after the write that caused it. A stale or wrongly updated running sum does not show in any descriptor byte. It shows only in byte 511, so every full-sector dump also checks that the 512 bytes sum to zero. Ordering faults show directly as a one-cycle difference: a read issued together with a write must return pre-write data, and a clear issued together with a write must leave an empty log.

// File: rtl/selog_pkg.sv
package selog_pkg;

    typedef struct packed {
        logic [31:0] lba;
        logic [7:0]  chkpt;
        logic [15:0] hours;
        logic [7:0]  status;
        logic [7:0]  num;
    } rec_t;

    // modulo-256 sum of the nine serialized bytes of one record
    function automatic logic [7:0] rec_sum(rec_t r);
        logic [7:0] s;
        s = r.num + r.status + r.hours[7:0] + r.hours[15:8] + r.chkpt
          + r.lba[7:0] + r.lba[15:8] + r.lba[23:16] + r.lba[31:24];
        return s;
    endfunction

    // byte at offset off within a descriptor, low byte first for wide fields
    function automatic logic [7:0] rec_byte(rec_t r, int unsigned off);
        logic [7:0] b;
        case (off)
            0:       b = r.num;
            1:       b = r.status;
            2:       b = r.hours[7:0];
            3:       b = r.hours[15:8];
            4:       b = r.chkpt;
            5:       b = r.lba[7:0];
            6:       b = r.lba[15:8];
            7:       b = r.lba[23:16];
            8:       b = r.lba[31:24];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/selog_store.sv
module selog_store
    import selog_pkg::*;
#(
    parameter int unsigned SLOTS = 21,
    localparam int unsigned PW   = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr_en,
    input  rec_t                   wr_rec,
    output rec_t [SLOTS-1:0]       slots,
    output logic [PW-1:0]          ptr,
    output logic [7:0]             body_sum
);

    typedef struct packed {
        rec_t [SLOTS-1:0] slot;
        logic [PW-1:0]    ptr;
        logic [7:0]       sum;
    } st_t;

    st_t st_d, st_q;
    logic [PW-1:0] wslot;

    always_comb begin
        st_d  = st_q;
        wslot = (st_q.ptr == PW'(SLOTS)) ? '0 : st_q.ptr;
        if (clr) begin
            st_d = '0;
        end else if (wr_en) begin
            st_d.slot[wslot] = wr_rec;
            st_d.ptr         = wslot + PW'(1);
            st_d.sum         = st_q.sum - rec_sum(st_q.slot[wslot]) + rec_sum(wr_rec);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slots    = st_q.slot;
    assign ptr      = st_q.ptr;
    assign body_sum = st_q.sum;

endmodule

// File: rtl/selog_ser.sv
module selog_ser
    import selog_pkg::*;
#(
    parameter int unsigned SLOTS        = 21,
    parameter int unsigned DESC_BYTES   = 24,
    parameter int unsigned SECTOR_BYTES = 512,
    parameter logic [15:0] REVISION     = 16'h0001,
    localparam int unsigned PW          = $clog2(SLOTS + 1),
    localparam int unsigned IW          = $clog2(SECTOR_BYTES),
    localparam int unsigned DESC_BASE   = 2,
    localparam int unsigned DESC_END    = DESC_BASE + SLOTS * DESC_BYTES,
    localparam int unsigned PTR_OFS     = SECTOR_BYTES - 4,
    localparam int unsigned CSUM_OFS    = SECTOR_BYTES - 1
) (
    input  logic [IW-1:0]          idx,
    input  rec_t [SLOTS-1:0]       slots,
    input  logic [PW-1:0]          ptr,
    input  logic [7:0]             body_sum,
    output logic [7:0]             byte_out
);

    int unsigned i, rel, s, o;
    logic [7:0]  csum;

    always_comb begin
        i    = int'(idx);
        rel  = (i >= DESC_BASE) ? i - DESC_BASE : 0;
        s    = rel / DESC_BYTES;
        o    = rel % DESC_BYTES;
        csum = 8'h00 - (REVISION[7:0] + REVISION[15:8] + 8'(ptr) + body_sum);
        if (i == 0)                              byte_out = REVISION[7:0];
        else if (i == 1)                         byte_out = REVISION[15:8];
        else if (i < DESC_END && s < SLOTS)      byte_out = rec_byte(slots[s], o);
        else if (i == PTR_OFS)                   byte_out = 8'(ptr);
        else if (i == CSUM_OFS)                  byte_out = csum;
        else                                     byte_out = 8'h00;
    end

endmodule

// File: rtl/selog_top.sv
module selog_top
    import selog_pkg::*;
#(
    parameter int unsigned SLOTS        = 21,
    parameter int unsigned DESC_BYTES   = 24,
    parameter int unsigned SECTOR_BYTES = 512,
    localparam int unsigned PW          = $clog2(SLOTS + 1),
    localparam int unsigned IW          = $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [7:0]    wr_test_num,
    input  logic [7:0]    wr_status,
    input  logic [15:0]   wr_hours,
    input  logic [7:0]    wr_chkpt,
    input  logic [31:0]   wr_lba,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          rd_valid
);

    typedef struct packed {
        logic [7:0] data;
        logic       valid;
    } rd_t;

    rec_t             wr_rec;
    rec_t [SLOTS-1:0] slots;
    logic [PW-1:0]    cur_ptr;
    logic [7:0]       body_sum;
    logic [7:0]       ser_byte;
    rd_t              rd_d, rd_q;

    assign wr_rec = '{lba: wr_lba, chkpt: wr_chkpt, hours: wr_hours,
                      status: wr_status, num: wr_test_num};

    selog_store #(.SLOTS(SLOTS)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_rec(wr_rec),
        .slots(slots), .ptr(cur_ptr), .body_sum(body_sum)
    );

    selog_ser #(.SLOTS(SLOTS), .DESC_BYTES(DESC_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_ser (
        .idx(rd_idx), .slots(slots), .ptr(cur_ptr), .body_sum(body_sum),
        .byte_out(ser_byte)
    );

    // read samples pre-write state, so a same-cycle write is not visible
    always_comb begin
        rd_d.valid = rd_en;
        rd_d.data  = rd_en ? ser_byte : rd_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data  = rd_q.data;
    assign rd_valid = rd_q.valid;

endmodule

// File: rtl/selog_chk.sv
module selog_chk #(
    parameter int unsigned SLOTS = 21,
    parameter int unsigned PW    = 5,
    parameter int unsigned IW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [IW-1:0] rd_idx,
    input logic [7:0]    rd_data,
    input logic          rd_valid,
    input logic [PW-1:0] ptr
);

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(SLOTS));

    // R1
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ptr == '0);

    // R6
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && ptr == PW'(SLOTS)) |=> ptr == PW'(1));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && ptr < PW'(SLOTS)) |=> ptr == $past(ptr) + PW'(1));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(ptr));

    // R9
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R2
    rev_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == '0) |=> rd_data == 8'h01);

endmodule

bind selog_top selog_chk #(.SLOTS(SLOTS), .PW(PW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .rd_en(rd_en),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid), .ptr(cur_ptr)
);

// File: tb/selog_top_bench.sv
`timescale 1ns/1ps
module selog_top_bench;

    localparam int NSLOT = 21;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        clr = 0;
    logic        wr_en = 0;
    logic [7:0]  wr_test_num = 0;
    logic [7:0]  wr_status = 0;
    logic [15:0] wr_hours = 0;
    logic [7:0]  wr_chkpt = 0;
    logic [31:0] wr_lba = 0;
    logic        rd_en = 0;
    logic [8:0]  rd_idx = 0;
    logic [7:0]  rd_data;
    logic        rd_valid;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  m_num [NSLOT];
    logic [7:0]  m_st  [NSLOT];
    logic [15:0] m_hr  [NSLOT];
    logic [7:0]  m_ck  [NSLOT];
    logic [31:0] m_lba [NSLOT];
    int          m_ptr = 0;

    always #4 clk = ~clk;

    selog_top u_selog_top (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
        .wr_test_num(wr_test_num), .wr_status(wr_status), .wr_hours(wr_hours),
        .wr_chkpt(wr_chkpt), .wr_lba(wr_lba), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic void model_clear();
        for (int k = 0; k < NSLOT; k++) begin
            m_num[k] = 0; m_st[k] = 0; m_hr[k] = 0; m_ck[k] = 0; m_lba[k] = 0;
        end
        m_ptr = 0;
    endfunction

    function automatic logic [7:0] body_byte(int idx);
        int s, o;
        if (idx == 0) return 8'h01;
        if (idx == 1) return 8'h00;
        if (idx == 508) return 8'(m_ptr);
        if (idx >= 2 && idx < 2 + 24 * NSLOT) begin
            s = (idx - 2) / 24;
            o = (idx - 2) % 24;
            case (o)
                0: return m_num[s];
                1: return m_st[s];
                2: return m_hr[s][7:0];
                3: return m_hr[s][15:8];
                4: return m_ck[s];
                5: return m_lba[s][7:0];
                6: return m_lba[s][15:8];
                7: return m_lba[s][23:16];
                8: return m_lba[s][31:24];
                default: return 8'h00;
            endcase
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_byte(int idx);
        logic [7:0] sum;
        if (idx != 511) return body_byte(idx);
        sum = 0;
        for (int j = 0; j < 511; j++) sum = sum + body_byte(j);
        return 8'h00 - sum;
    endfunction

    function automatic string req_of(int idx);
        int o;
        if (idx < 2) return "R2";
        if (idx == 508) return "R5";
        if (idx == 511) return "R7";
        if (idx >= 2 && idx < 2 + 24 * NSLOT) begin
            o = (idx - 2) % 24;
            if (o == 2 || o == 3 || (o >= 5 && o <= 8)) return "R4";
            if (o < 9) return "R3";
        end
        return "R8";
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] num, input logic [7:0] st,
                            input logic [15:0] hr, input logic [7:0] ck,
                            input logic [31:0] lba);
        int s;
        @(negedge clk);
        wr_en = 1; wr_test_num = num; wr_status = st; wr_hours = hr;
        wr_chkpt = ck; wr_lba = lba;
        @(negedge clk);
        wr_en = 0;
        s = (m_ptr == NSLOT) ? 0 : m_ptr;
        m_num[s] = num; m_st[s] = st; m_hr[s] = hr; m_ck[s] = ck; m_lba[s] = lba;
        m_ptr = s + 1;
    endtask

    task automatic read_byte(input int idx, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1; rd_idx = 9'(idx);
        @(negedge clk);
        rd_en = 0;
        d = rd_data;
    endtask

    task automatic check_sector(string tag);
        logic [7:0] d;
        logic [7:0] tot;
        tot = 0;
        for (int i = 0; i < 512; i++) begin
            read_byte(i, d);
            tot = tot + d;
            check(req_of(i), $sformatf("%s byte %0d", tag, i), d, exp_byte(i));
        end
        check("R7", {tag, " sector sum"}, tot, 0);
    endtask

    task automatic t_reset();
        model_clear();
        check_sector("after reset R1");
    endtask

    task automatic t_single();
        logic [7:0] d;
        do_write(8'h81, 8'h25, 16'h1234, 8'h07, 32'hDEADBEEF);
        read_byte(4, d);  check("R4", "hours low byte", d, 8'h34);
        read_byte(7, d);  check("R4", "lba low byte", d, 8'hEF);
        read_byte(10, d); check("R4", "lba high byte", d, 8'hDE);
        read_byte(2, d);  check("R3", "test number", d, 8'h81);
        check_sector("single R3");
    endtask

    task automatic t_fill();
        logic [7:0] d;
        for (int k = 1; k < NSLOT; k++) begin
            do_write(8'(k), 8'(k * 3), 16'(k * 257), 8'(k + 64), 32'hA5000000 | (k << 8) | k);
            read_byte(508, d);
            check("R5", $sformatf("pointer after write %0d", k + 1), d, k + 1);
        end
        check_sector("full R5");
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        do_write(8'hF0, 8'h11, 16'hBEEF, 8'h22, 32'h01020304);
        read_byte(508, d);
        check("R6", "pointer after 22nd write", d, 1);
        read_byte(2, d);
        check("R6", "slot 0 replaced", d, 8'hF0);
        read_byte(2 + 24, d);
        check("R6", "slot 1 kept", d, 8'h01);
        for (int k = 0; k < 3; k++)
            do_write(8'(8'hF1 + k), 8'h40, 16'(k), 8'h33, 32'(k * 77));
        check_sector("wrapped R6");
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        int old;
        old = m_ptr;
        @(negedge clk);
        wr_en = 1; wr_test_num = 8'h5A; wr_status = 8'h01; wr_hours = 16'h0042;
        wr_chkpt = 8'h09; wr_lba = 32'h0000CAFE;
        rd_en = 1; rd_idx = 9'd508;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check("R10", "pointer read with write", rd_data, old);
        m_num[old] = 8'h5A; m_st[old] = 8'h01; m_hr[old] = 16'h0042;
        m_ck[old] = 8'h09; m_lba[old] = 32'h0000CAFE; m_ptr = old + 1;
        read_byte(508, d);
        check("R10", "pointer after write", d, old + 1);
        read_byte(511, d);
        check("R7", "checksum after write", d, exp_byte(511));
    endtask

    task automatic t_latency();
        @(negedge clk);
        check("R9", "valid idle", rd_valid, 0);
        rd_en = 1; rd_idx = 9'd1;
        @(negedge clk);
        rd_en = 0;
        check("R9", "valid one cycle later", rd_valid, 1);
        check("R2", "revision high byte", rd_data, 8'h00);
        @(negedge clk);
        check("R9", "valid drops", rd_valid, 0);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        @(negedge clk);
        clr = 1;
        @(negedge clk);
        clr = 0;
        model_clear();
        check_sector("cleared R1");
        @(negedge clk);
        clr = 1; wr_en = 1; wr_test_num = 8'h77; wr_lba = 32'h12345678;
        @(negedge clk);
        clr = 0; wr_en = 0;
        read_byte(508, d);
        check("R11", "pointer after clear+write", d, 0);
        read_byte(2, d);
        check("R11", "slot 0 after clear+write", d, 0);
        read_byte(511, d);
        check("R11", "checksum after clear+write", d, exp_byte(511));
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_latency();
        t_single();
        t_fill();
        t_wrap();
        t_same_cycle();
        t_clear();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule